// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Run-Time Write Policy

This block is a direct-mapped data cache between a processor word port and a plain main-memory word port. With default parameters it holds 4096 32-bit words in 256 lines of 16 words. Every line carries a valid flag and a stored tag. A dirty flag marks lines changed by stores that have not yet reached memory. A single policy input picks, cycle by cycle, between write-through and write-back handling of stores.

The processor raises a request and holds its address, data, write flag and byte mask steady while the stall output is high. A read hit returns data with no stall, in the cycle it is presented. On a miss the block stalls the processor. If the victim line is dirty, its sixteen words go back to memory first. The block then fetches the new line one word at a time, installs the tag and valid flag, and retries the access, which then hits and completes.

The memory port has a fixed latency. For each word the cache holds a read or write strobe, with a steady address, for `MEM_LAT` cycles. This covers one cycle to send the address, fifteen for the DRAM access and one to move the word. Read data is taken in the last of those cycles.

Top module: `cache_dm`

## Requirements
- R1: After reset every line is invalid, both memory strobes and the stall output are low while no request is present, and the first read of any address misses.
- R2: A read miss on a clean or invalid line holds the stall high for exactly 1 + 16*MEM_LAT cycles. It fetches the line's words 0 to 15 in ascending order, each with `mem_rd` high and the address steady for MEM_LAT cycles. Then it returns the memory word with the stall low.
- R3: The byte address splits as tag = bits [31:14], line index = bits [13:6], word in line = bits [5:2]; bits [1:0] must be zero. A read whose line is valid and holds the same tag completes with no stall and returns the cached word.
- R4: A read whose index matches a valid line but whose tag differs is a miss that replaces the line; the replaced block then misses again.
- R5: With the policy input low (write-through), a store that hits stalls for 1 + MEM_LAT cycles, writes the word to memory, and also updates the cached copy.
- R6: In write-through mode a store that misses writes memory in 1 + MEM_LAT stall cycles and allocates no line, so a later read of that address takes a full miss.
- R7: With the policy input high (write-back), a store that hits completes with no stall and no memory write, leaving memory unchanged while later reads return the new value.
- R8: In write-back mode a store that misses fetches the line (1 + 16*MEM_LAT stall cycles for a clean victim), merges the store into it and marks it dirty, with no memory write.
- R9: A miss on a valid dirty line first writes all 16 victim words to memory at the victim's own tag and index, in ascending order with all byte lanes enabled, then fetches the new line: 1 + 32*MEM_LAT stall cycles in all.
- R10: The 4-bit byte mask (bit k enables bits 8k+7..8k) limits the bytes changed both in the cached word and in the word written through to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | Store policy: 1 write-back, 0 write-through |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte mask |
| cpu_rdata | output | 32 | Load data, valid when the request is not stalled |
| cpu_stall | output | 1 | High while the request cannot complete |
| mem_rd | output | 1 | Memory word read strobe, held MEM_LAT cycles |
| mem_wr | output | 1 | Memory word write strobe, held MEM_LAT cycles |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte mask |
| mem_rdata | input | 32 | Memory read data, taken in the last strobe cycle |

## Verification
Hits complete in the cycle they are presented. A write-through store finishes MEM_LAT + 1 cycles after it is presented, a clean miss after 16*MEM_LAT + 1 cycles, and a dirty miss after 32*MEM_LAT + 1 cycles. The bench drives each request after a falling edge and counts falling edges until the stall output is seen low, so each count matches one of those figures exactly. Data and memory contents are sampled in that completing cycle, away from the rising edge. The bench's memory model logs each new strobed address, so the order of fetch and write-back words can be checked.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_EVICT = 2'd1,
    S_FILL  = 2'd2,
    S_WTHRU = 2'd3
  } cstate_t;

  // byte-lane merge: lane k of nw replaces lane k of old when be[k] is set
  function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                             input logic [31:0] nw,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = be[k] ? nw[8*k +: 8] : old[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  input  logic             dirty_clr,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tags_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_set) dirty_q[idx] <= 1'b1;
      if (dirty_clr) dirty_q[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tags_q[idx] <= fill_tag;
  end

  assign tag_o   = tags_q[idx];
  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];

  // R2: a completed fill leaves the line valid
  assert_fill_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> valid_q[$past(idx)]);

  // R9: only valid lines may be dirty
  assert_dirty_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_o |-> valid_o);

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store import cache_pkg::*; #(
  parameter int IDX_W  = 8,
  parameter int OFFS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFFS_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  input  logic              we,
  input  logic [OFFS_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be
);
  localparam int DEPTH = 1 << (IDX_W + OFFS_W);
  localparam int AW    = IDX_W + OFFS_W;

  logic [31:0]   words_q [DEPTH];
  logic [AW-1:0] wa;

  assign wa = {idx, wr_word};

  always_ff @(posedge clk) begin
    if (we) words_q[wa] <= lane_merge(words_q[wa], wr_data, wr_be);
  end

  assign rd_data = words_q[{idx, rd_word}];

  // R10: enabled lanes take the new data after a write
  assert_lanes_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((words_q[$past(wa)] & lane_mask($past(wr_be))) ==
            ($past(wr_data) & lane_mask($past(wr_be)))));

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl import cache_pkg::*; #(
  parameter int TAG_W   = 18,
  parameter int IDX_W   = 8,
  parameter int OFFS_W  = 4,
  parameter int MEM_LAT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_wdata,
  input  logic [3:0]        cpu_be,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [OFFS_W-1:0] a_word,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [31:0]       line_word,
  output logic              cpu_stall,
  output logic [OFFS_W-1:0] ds_rd_word,
  output logic              ds_we,
  output logic [OFFS_W-1:0] ds_wr_word,
  output logic [31:0]       ds_wdata,
  output logic [3:0]        ds_be,
  output logic              ts_fill,
  output logic              ts_dirty_set,
  output logic              ts_dirty_clr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [TAG_W+IDX_W+OFFS_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata
);
  localparam int LAT_W = $clog2(MEM_LAT + 1);
  localparam logic [LAT_W-1:0]  LAT_END  = LAT_W'(MEM_LAT - 1);
  localparam logic [OFFS_W-1:0] WORD_END = '1;

  cstate_t           state_q, state_d;
  logic [LAT_W-1:0]  lat_cnt_q;
  logic [OFFS_W-1:0] word_cnt_q;
  logic              wt_done_q;

  // named internal events
  logic hit, lat_last, acc_done, miss_go, word_last;

  assign hit       = line_valid && (line_tag == a_tag);
  assign lat_last  = (lat_cnt_q == LAT_END);
  assign word_last = (word_cnt_q == WORD_END);

  always_comb begin
    state_d      = state_q;
    acc_done     = 1'b0;
    miss_go      = 1'b0;
    ds_we        = 1'b0;
    ts_fill      = 1'b0;
    ts_dirty_set = 1'b0;
    ts_dirty_clr = 1'b0;
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    mem_addr     = {a_tag, a_idx, a_word};
    mem_wdata    = cpu_wdata;
    mem_be       = cpu_be;
    ds_rd_word   = a_word;
    unique case (state_q)
      S_IDLE: begin
        if (cpu_req) begin
          if (!cpu_we) begin
            if (hit) acc_done = 1'b1;
            else     miss_go  = 1'b1;
          end else if (wt_done_q) begin
            acc_done = 1'b1;
            ds_we    = hit;
          end else if (wb_mode) begin
            if (hit) begin
              acc_done     = 1'b1;
              ds_we        = 1'b1;
              ts_dirty_set = 1'b1;
            end else begin
              miss_go = 1'b1;
            end
          end else begin
            state_d = S_WTHRU;
          end
        end
        if (miss_go) state_d = (line_valid && line_dirty) ? S_EVICT : S_FILL;
      end
      S_EVICT: begin
        mem_wr     = 1'b1;
        mem_addr   = {line_tag, a_idx, word_cnt_q};
        mem_wdata  = line_word;
        mem_be     = 4'hF;
        ds_rd_word = word_cnt_q;
        if (lat_last && word_last) begin
          ts_dirty_clr = 1'b1;
          state_d      = S_FILL;
        end
      end
      S_FILL: begin
        mem_rd   = 1'b1;
        mem_addr = {a_tag, a_idx, word_cnt_q};
        if (lat_last) begin
          ds_we = 1'b1;
          if (word_last) begin
            ts_fill = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
      S_WTHRU: begin
        mem_wr = 1'b1;
        if (lat_last) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // data-array write source: memory word during a fill, processor otherwise
  assign ds_wr_word = (state_q == S_FILL) ? word_cnt_q : a_word;
  assign ds_wdata   = (state_q == S_FILL) ? mem_rdata  : cpu_wdata;
  assign ds_be      = (state_q == S_FILL) ? 4'hF       : cpu_be;

  assign cpu_stall = (state_q != S_IDLE) || (cpu_req && !acc_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      lat_cnt_q  <= '0;
      word_cnt_q <= '0;
      wt_done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE || lat_last) lat_cnt_q <= '0;
      else                               lat_cnt_q <= lat_cnt_q + 1'b1;
      if (state_q == S_IDLE) word_cnt_q <= '0;
      else if (lat_last && (state_q == S_EVICT || state_q == S_FILL))
        word_cnt_q <= word_cnt_q + 1'b1;
      if (state_q == S_WTHRU && lat_last) wt_done_q <= 1'b1;
      else if (acc_done)                  wt_done_q <= 1'b0;
    end
  end

  // R9: the memory port never reads and writes at once
  assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R2: the address stays put for the whole strobe window of a word
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && lat_cnt_q != '0) |-> $stable(mem_addr));

  // R7: a write-back store hit causes no memory traffic next cycle
  assert_wb_hit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && cpu_we && wb_mode && !wt_done_q) |=> (!mem_wr && !mem_rd));

  // R5: the processor stays stalled inside a memory transfer
  assert_stall_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && !lat_last) |=> cpu_stall);

endmodule

// File: rtl/cache_dm.sv
module cache_dm import cache_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int OFFS_W  = 4,
  parameter int IDX_W   = 8,
  parameter int MEM_LAT = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wb_mode,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [31:0]         cpu_wdata,
  input  logic [3:0]          cpu_be,
  output logic [31:0]         cpu_rdata,
  output logic                cpu_stall,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  output logic [3:0]          mem_be,
  input  logic [31:0]         mem_rdata
);
  localparam int TAG_W   = ADDR_W - 2 - OFFS_W - IDX_W;
  localparam int WORD_LO = 2;
  localparam int IDX_LO  = WORD_LO + OFFS_W;
  localparam int TAG_LO  = IDX_LO + IDX_W;

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LO];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[TAG_LO-1:IDX_LO];
  endfunction
  function automatic logic [OFFS_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[IDX_LO-1:WORD_LO];
  endfunction

  logic [TAG_W-1:0]  a_tag, line_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [OFFS_W-1:0] a_word, ds_rd_word, ds_wr_word;
  logic              line_valid, line_dirty;
  logic [31:0]       line_word, ds_wdata;
  logic [3:0]        ds_be;
  logic              ds_we, ts_fill, ts_dirty_set, ts_dirty_clr;

  assign a_tag  = f_tag(cpu_addr);
  assign a_idx  = f_idx(cpu_addr);
  assign a_word = f_word(cpu_addr);

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(a_idx),
    .fill(ts_fill), .fill_tag(a_tag),
    .dirty_set(ts_dirty_set), .dirty_clr(ts_dirty_clr),
    .tag_o(line_tag), .valid_o(line_valid), .dirty_o(line_dirty)
  );

  cache_data_store #(.IDX_W(IDX_W), .OFFS_W(OFFS_W)) u_data (
    .clk(clk), .rst_n(rst_n), .idx(a_idx),
    .rd_word(ds_rd_word), .rd_data(line_word),
    .we(ds_we), .wr_word(ds_wr_word), .wr_data(ds_wdata), .wr_be(ds_be)
  );

  cache_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W), .MEM_LAT(MEM_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .a_tag(a_tag), .a_idx(a_idx), .a_word(a_word),
    .line_tag(line_tag), .line_valid(line_valid), .line_dirty(line_dirty),
    .line_word(line_word), .cpu_stall(cpu_stall),
    .ds_rd_word(ds_rd_word), .ds_we(ds_we), .ds_wr_word(ds_wr_word),
    .ds_wdata(ds_wdata), .ds_be(ds_be),
    .ts_fill(ts_fill), .ts_dirty_set(ts_dirty_set), .ts_dirty_clr(ts_dirty_clr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  assign cpu_rdata = line_word;

  // R3: requests are word aligned
  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[1:0] == 2'b00));

  // R1: with no request and nothing pending, the port is quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !mem_rd && !mem_wr) |-> !cpu_stall);

endmodule

// File: tb/cache_dm_bench.sv
module cache_dm_bench;
  localparam int PERIOD = 10;
  localparam int LAT    = 17;
  localparam int MISS   = 1 + 16 * LAT;
  localparam int DMISS  = 1 + 32 * LAT;
  localparam int WTS    = 1 + LAT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall, mem_rd, mem_wr;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int wr_cycles = 0;
  logic [29:0] rd_log[$];
  logic [29:0] wr_log[$];
  logic [31:0] mstore [logic [29:0]];

  always #(PERIOD/2) clk = ~clk;

  cache_dm #(.MEM_LAT(LAT)) u_cache_dm (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] seed(input logic [29:0] a);
    return {a, 2'b00} ^ 32'hA5C3_0F1E;
  endfunction
  function automatic logic [31:0] mrd(input logic [29:0] a);
    return mstore.exists(a) ? mstore[a] : seed(a);
  endfunction
  function automatic logic [31:0] mix(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction
  function automatic logic [31:0] baddr(input int tg, input int ix, input int w);
    return {tg[17:0], ix[7:0], w[3:0], 2'b00};
  endfunction

  // memory model: fixed latency, data presented from the held address
  logic        prv_rd = 1'b0, prv_wr = 1'b0;
  logic [29:0] prv_a = '0;
  always @(posedge clk) begin
    if (mem_wr) begin
      mstore[mem_addr] = mix(mrd(mem_addr), mem_wdata, mem_be);
      wr_cycles++;
      if (!prv_wr || mem_addr != prv_a) wr_log.push_back(mem_addr);
    end
    if (mem_rd && (!prv_rd || mem_addr != prv_a)) rd_log.push_back(mem_addr);
    prv_rd = mem_rd; prv_wr = mem_wr; prv_a = mem_addr;
  end
  always @(negedge clk) mem_rdata <= mrd(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    cyc = 0;
    #1;
    while (cpu_stall && cyc < 3000) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_reset_and_read_miss;
    logic [31:0] rd; int cyc;
    @(negedge clk); #1;
    chk("R1 stall low idle", 32'(cpu_stall), 0);
    chk("R1 memory quiet", 32'({mem_rd, mem_wr}), 0);
    rd_log.delete();
    access(1'b0, baddr(1, 3, 5), 0, 0, rd, cyc);
    chk("R1 R2 miss stall cycles", cyc, MISS);
    chk("R2 read data", rd, seed(baddr(1, 3, 5) >> 2));
    chk("R2 fetch count", rd_log.size(), 16);
    for (int w = 0; w < 16; w++)
      if (w < rd_log.size()) chk("R2 fetch order", 32'(rd_log[w]), baddr(1, 3, w) >> 2);
  endtask

  task automatic t_hits;
    logic [31:0] rd; int cyc;
    access(1'b0, baddr(1, 3, 0), 0, 0, rd, cyc);
    chk("R3 hit word0 cycles", cyc, 0);
    chk("R3 hit word0 data", rd, seed(baddr(1, 3, 0) >> 2));
    access(1'b0, baddr(1, 3, 15), 0, 0, rd, cyc);
    chk("R3 hit word15 cycles", cyc, 0);
    chk("R3 hit word15 data", rd, seed(baddr(1, 3, 15) >> 2));
  endtask

  task automatic t_conflict;
    logic [31:0] rd; int cyc;
    access(1'b0, baddr(2, 3, 5), 0, 0, rd, cyc);
    chk("R4 conflict miss cycles", cyc, MISS);
    chk("R4 conflict data", rd, seed(baddr(2, 3, 5) >> 2));
    access(1'b0, baddr(1, 3, 5), 0, 0, rd, cyc);
    chk("R4 replaced block misses", cyc, MISS);
  endtask

  task automatic t_wt_store_hit;
    logic [31:0] rd, exp; int cyc;
    logic [29:0] wa = 30'(baddr(1, 3, 2) >> 2);
    wb_mode = 1'b0;
    exp = mix(seed(wa), 32'h1122_3344, 4'b0101);
    access(1'b1, baddr(1, 3, 2), 32'h1122_3344, 4'b0101, rd, cyc);
    chk("R5 wt store cycles", cyc, WTS);
    chk("R5 R10 memory bytes", mrd(wa), exp);
    access(1'b0, baddr(1, 3, 2), 0, 0, rd, cyc);
    chk("R5 cached copy hit", cyc, 0);
    chk("R5 R10 cached bytes", rd, exp);
  endtask

  task automatic t_wt_store_miss;
    logic [31:0] rd; int cyc;
    logic [29:0] wa = 30'(baddr(7, 9, 1) >> 2);
    wb_mode = 1'b0;
    access(1'b1, baddr(7, 9, 1), 32'hCAFE_F00D, 4'hF, rd, cyc);
    chk("R6 wt miss cycles", cyc, WTS);
    chk("R6 memory written", mrd(wa), 32'hCAFE_F00D);
    access(1'b0, baddr(7, 9, 1), 0, 0, rd, cyc);
    chk("R6 no allocate", cyc, MISS);
    chk("R6 data after fill", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_wb_store_hit;
    logic [31:0] rd; int cyc, w0;
    logic [29:0] wa = 30'(baddr(7, 9, 4) >> 2);
    wb_mode = 1'b1;
    w0 = wr_cycles;
    access(1'b1, baddr(7, 9, 4), 32'hDEAD_BEEF, 4'b1100, rd, cyc);
    chk("R7 wb hit cycles", cyc, 0);
    chk("R7 no memory write", wr_cycles - w0, 0);
    chk("R7 memory unchanged", mrd(wa), seed(wa));
    access(1'b0, baddr(7, 9, 4), 0, 0, rd, cyc);
    chk("R7 R10 read merged", rd, mix(seed(wa), 32'hDEAD_BEEF, 4'b1100));
  endtask

  task automatic t_dirty_evict;
    logic [31:0] rd; int cyc;
    logic [29:0] wa = 30'(baddr(7, 9, 4) >> 2);
    wr_log.delete();
    access(1'b0, baddr(8, 9, 0), 0, 0, rd, cyc);
    chk("R9 dirty miss cycles", cyc, DMISS);
    chk("R9 words written back", wr_log.size(), 16);
    if (wr_log.size() > 15) begin
      chk("R9 first victim addr", 32'(wr_log[0]), baddr(7, 9, 0) >> 2);
      chk("R9 last victim addr", 32'(wr_log[15]), baddr(7, 9, 15) >> 2);
    end
    chk("R9 victim data in memory", mrd(wa), mix(seed(wa), 32'hDEAD_BEEF, 4'b1100));
    chk("R9 new line data", rd, seed(baddr(8, 9, 0) >> 2));
  endtask

  task automatic t_wb_store_miss;
    logic [31:0] rd; int cyc, w0;
    logic [29:0] wa = 30'(baddr(5, 20, 7) >> 2);
    wb_mode = 1'b1;
    w0 = wr_cycles;
    access(1'b1, baddr(5, 20, 7), 32'h0BAD_CAFE, 4'hF, rd, cyc);
    chk("R8 wb miss cycles", cyc, MISS);
    chk("R8 no memory write", wr_cycles - w0, 0);
    access(1'b0, baddr(5, 20, 7), 0, 0, rd, cyc);
    chk("R8 allocated hit", cyc, 0);
    chk("R8 merged data", rd, 32'h0BAD_CAFE);
    chk("R8 memory stale", mrd(wa), seed(wa));
    access(1'b0, baddr(6, 20, 0), 0, 0, rd, cyc);
    chk("R8 line marked dirty", cyc, DMISS);
    chk("R8 written back", mrd(wa), 32'h0BAD_CAFE);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_and_read_miss();
    t_hits();
    t_conflict();
    t_wt_store_hit();
    t_wt_store_miss();
    t_wb_store_hit();
    t_dirty_evict();
    t_wb_store_miss();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule